// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block sits on the host side of an enhanced parallel port link. It turns one access on a simple register port into one complete, interlocked bus cycle on an 8-bit shared address/data bus. Offset 3 produces an address cycle. Offsets 4 to 7 all produce the same data cycle. The direction of the access picks a write cycle or a read cycle. The engine drives the write-direction line, the address and data strobes, and the output enable of the shared bus. Every step waits for the peripheral's handshake line, so a slow peripheral stretches the cycle instead of losing data.

Offsets 0 to 2 are local registers and never touch the bus. Offset 0 holds a byte that is driven on the bus while the engine is idle. Offset 1 is a read-only status byte. Offset 2 is a small control byte. It can hold the link in reset, which ends enhanced operation; while the link is held in reset, bus-cycle offsets complete without any strobe. The control byte also gates a level interrupt that latches the rising edge of the peripheral's interrupt line. A cycle whose handshake stalls is abandoned after a parameterised number of clocks, and a sticky error flag records it.

Top module: `epp_host_engine`

## Requirements
- R1: After reset, write_n, astrobe_n, dstrobe_n and init_n are 1, bus_oe is 1 with bus_out 0x00, and busy, done and irq are 0.
- R2: An access to offset 3 strobes only astrobe_n, and an access to any of offsets 4, 5, 6 or 7 strobes only dstrobe_n. The two strobes are never low together.
- R3: In a write cycle, write_n is 0 and bus_oe is 1 from before the strobe falls until after it rises. bus_out holds the written byte without change. The strobe stays low until wait_n has been seen high.
- R4: In a read cycle, write_n is 1 and bus_oe is 0 while the strobe is low. rdata returns the bus_in byte sampled once wait_n is seen high, and it is valid in the cycle where done is 1.
- R5: A strobe falls only while wait_n is seen low (peripheral ready). done for a bus cycle comes only after wait_n has returned low following the strobe's release.
- R6: If wait_n does not reach the level a phase waits for within TIMEOUT_CYC clocks, the cycle is abandoned. The strobe is released, done pulses, a read returns 0x00, and status bit 0 is set. That bit stays set until a control write with bit 2 set.
- R7: Offset 0 is read/write, and its byte is on bus_out with bus_oe 1 while idle. Offset 1 reads {bit7 peripheral ready (wait_n low), bit6 interrupt line level, bits5:2 zero, bit1 interrupt pending, bit0 timeout error}. Offset 2 reads {6'b0, link reset, interrupt enable}. Local accesses raise done on the next clock.
- R8: Control bit 1 drives init_n low. While it is set, accesses to offsets 3 to 7 give done with no strobe, and reads return 0x00.
- R9: A rising edge on intr sets status bit 1. A control write with bit 3 set clears it. irq is 1 exactly while that bit and control bit 0 are both set, one clock later.
- R10: A request presented while busy is 1 is ignored. It changes no register and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request, accepted when busy is 0 |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_addr | input | 3 | Register offset |
| req_wdata | input | DATA_W | Write byte |
| done | output | 1 | One-clock pulse when an access completes |
| busy | output | 1 | A bus cycle is in progress |
| rdata | output | DATA_W | Read result, valid with done |
| bus_out | output | DATA_W | Byte driven onto the shared bus |
| bus_oe | output | 1 | Host output enable for the shared bus |
| bus_in | input | DATA_W | Byte seen on the shared bus |
| write_n | output | 1 | Low for a write cycle, high for a read cycle |
| astrobe_n | output | 1 | Address strobe, active low |
| dstrobe_n | output | 1 | Data strobe, active low |
| wait_n | input | 1 | Peripheral handshake: low means ready, high means acknowledge |
| intr | input | 1 | Peripheral interrupt line |
| init_n | output | 1 | Link reset, active low |
| irq | output | 1 | Interrupt to the host |

## Verification
The assertions assume that the peripheral follows the handshake. It raises wait_n only while a strobe is low, and drops it again only after the strobe has risen. They also assume that requests come from a requester that waits for done. The bench's peripheral model keeps to these rules: it reacts only to a falling strobe, waits a random one to five clocks before each edge of wait_n, and presents bus_in only during reads. Only the directed cases break the rules on purpose. One holds wait_n high before a cycle, one never answers (timeout), and one issues a request while busy.

// File: rtl/epp_pkg.sv
package epp_pkg;

  // Bus cycle phases of the engine
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // no cycle; local registers on the bus
    PH_PRE  = 2'd1,   // direction and byte set, waiting for ready
    PH_STRB = 2'd2,   // strobe low, waiting for acknowledge
    PH_REL  = 2'd3    // strobe high, waiting for ready again
  } phase_e;

  // Register offsets
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_ADDR = 3'd3;

  // Status bit positions
  localparam int ST_ERR   = 0;
  localparam int ST_PEND  = 1;
  localparam int ST_INTR  = 6;
  localparam int ST_READY = 7;

  // Control bit positions
  localparam int CT_IRQEN   = 0;
  localparam int CT_LINKRST = 1;
  localparam int CT_ERRCLR  = 2;
  localparam int CT_IRQCLR  = 3;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,     // accepted bus access
  input  logic   wait_hi,   // synchronised handshake level
  output phase_e phase,
  output phase_e phase_nxt,
  output logic   cap,       // sample the bus this clock
  output logic   fin,       // cycle ends this clock
  output logic   abort_o    // cycle abandoned this clock
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt;
  logic          expired;

  assign expired = (cnt == CW'(TIMEOUT_CYC - 1));

  always_comb begin
    phase_nxt = phase;
    cap       = 1'b0;
    fin       = 1'b0;
    abort_o   = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) phase_nxt = PH_PRE;
      PH_PRE: begin
        if (!wait_hi)      phase_nxt = PH_STRB;
        else if (expired) begin
          phase_nxt = PH_IDLE;
          abort_o   = 1'b1;
        end
      end
      PH_STRB: begin
        if (wait_hi) begin
          phase_nxt = PH_REL;
          cap       = 1'b1;
        end else if (expired) begin
          phase_nxt = PH_IDLE;
          abort_o   = 1'b1;
        end
      end
      PH_REL: begin
        if (!wait_hi) begin
          phase_nxt = PH_IDLE;
          fin       = 1'b1;
        end else if (expired) begin
          phase_nxt = PH_IDLE;
          abort_o   = 1'b1;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
    if (abort_o) fin = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_nxt;
      if (phase == PH_IDLE || phase_nxt != phase) cnt <= '0;
      else                                        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/epp_irq_unit.sv
module epp_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic intr_s,    // synchronised interrupt line
  input  logic irq_en,
  input  logic clr,
  output logic pend,
  output logic irq
);

  logic intr_d;
  logic rise;

  assign rise = intr_s & ~intr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_d <= 1'b0;
      pend   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      intr_d <= intr_s;
      pend   <= rise | (pend & ~clr);
      irq    <= pend & irq_en;
    end
  end

endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
  import epp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic              write_n,
  output logic              astrobe_n,
  output logic              dstrobe_n,
  input  logic              wait_n,
  input  logic              intr,
  output logic              init_n,
  output logic              irq
);

  localparam int CTRL_W = 2;

  // ---------------- input synchronisers ----------------
  logic wait_s, intr_s;

  epp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wait_sync (
    .clk(clk), .rst(rst), .d(wait_n), .q(wait_s)
  );

  epp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_intr_sync (
    .clk(clk), .rst(rst), .d(intr), .q(intr_s)
  );

  // ---------------- request decode ----------------
  phase_e phase, phase_nxt;
  logic   cap, fin, abort_c;
  logic   accept, is_bus, start, refuse, local_acc;

  logic [CTRL_W-1:0] ctrl_q;
  logic              err_q;
  logic              pend;

  assign accept    = req_valid && (phase == PH_IDLE);
  assign is_bus    = (req_addr >= OFS_ADDR);
  assign start     = accept && is_bus && !ctrl_q[CT_LINKRST];
  assign refuse    = accept && is_bus &&  ctrl_q[CT_LINKRST];
  assign local_acc = accept && !is_bus;

  epp_cycle_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .wait_hi(wait_s),
    .phase(phase), .phase_nxt(phase_nxt),
    .cap(cap), .fin(fin), .abort_o(abort_c)
  );

  // ---------------- cycle context ----------------
  logic              rd_q, adr_q;
  logic [DATA_W-1:0] wb_q, dreg_q;
  logic              rd_n, adr_n;
  logic [DATA_W-1:0] wb_n, dreg_n;

  logic ctrl_wr;
  logic data_wr;

  assign ctrl_wr = local_acc && req_write && (req_addr == OFS_CTRL);
  assign data_wr = local_acc && req_write && (req_addr == OFS_DATA);

  assign rd_n   = start ? !req_write                : rd_q;
  assign adr_n  = start ? (req_addr == OFS_ADDR)    : adr_q;
  assign wb_n   = start ? req_wdata                 : wb_q;
  assign dreg_n = data_wr ? req_wdata               : dreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      adr_q  <= 1'b0;
      wb_q   <= '0;
      dreg_q <= '0;
    end else begin
      rd_q   <= rd_n;
      adr_q  <= adr_n;
      wb_q   <= wb_n;
      dreg_q <= dreg_n;
    end
  end

  // ---------------- control and error ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= req_wdata[CTRL_W-1:0];
      if (abort_c)                              err_q <= 1'b1;
      else if (ctrl_wr && req_wdata[CT_ERRCLR]) err_q <= 1'b0;
    end
  end

  // ---------------- interrupt ----------------
  epp_irq_unit u_irq (
    .clk(clk), .rst(rst), .intr_s(intr_s),
    .irq_en(ctrl_q[CT_IRQEN]),
    .clr(ctrl_wr && req_wdata[CT_IRQCLR]),
    .pend(pend), .irq(irq)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] local_rd;

  always_comb begin
    status           = '0;
    status[ST_ERR]   = err_q;
    status[ST_PEND]  = pend;
    status[ST_INTR]  = intr_s;
    status[ST_READY] = ~wait_s;
  end

  always_comb begin
    unique case (req_addr)
      OFS_DATA: local_rd = dreg_q;
      OFS_STAT: local_rd = status;
      OFS_CTRL: local_rd = DATA_W'(ctrl_q);
      default:  local_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= local_acc | refuse | fin;
      if (local_acc && !req_write)   rdata <= local_rd;
      else if (refuse && !req_write) rdata <= '0;
      else if (abort_c)              rdata <= '0;
      else if (cap && rd_q)          rdata <= bus_in;
    end
  end

  // ---------------- registered pin drivers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      write_n   <= 1'b1;
      astrobe_n <= 1'b1;
      dstrobe_n <= 1'b1;
      bus_oe    <= 1'b1;
      bus_out   <= '0;
    end else if (phase_nxt == PH_IDLE) begin
      write_n   <= 1'b1;
      astrobe_n <= 1'b1;
      dstrobe_n <= 1'b1;
      bus_oe    <= 1'b1;
      bus_out   <= dreg_n;
    end else begin
      write_n   <= rd_n;
      bus_oe    <= !rd_n;
      bus_out   <= wb_n;
      astrobe_n <= !((phase_nxt == PH_STRB) &&  adr_n);
      dstrobe_n <= !((phase_nxt == PH_STRB) && !adr_n);
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign init_n = !ctrl_q[CT_LINKRST];

endmodule

// File: rtl/epp_host_checker.sv
module epp_host_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              write_n,
  input logic              astrobe_n,
  input logic              dstrobe_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic              init_n,
  input logic              done,
  input logic              busy,
  input logic              err_flag
);

  logic strb;
  assign strb = !astrobe_n || !dstrobe_n;

  // R2: never both strobes low
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!astrobe_n && !dstrobe_n));

  // R3: host drives the bus while a write strobe is low
  a_r3_write_drives: assert property (@(posedge clk) disable iff (rst)
    (strb && !write_n) |-> bus_oe);

  // R3: written byte held for the whole write cycle
  a_r3_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (busy && !write_n && $past(busy && !write_n)) |-> $stable(bus_out));

  // R4: host releases the bus while a read strobe is low
  a_r4_read_release: assert property (@(posedge clk) disable iff (rst)
    (strb && write_n) |-> !bus_oe);

  // R5: completion never overlaps a low strobe
  a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (astrobe_n && dstrobe_n));

  // R6: the error flag rises only out of a running cycle
  a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(busy));

  // R8: no strobe while the link is held in reset
  a_r8_init_quiet: assert property (@(posedge clk) disable iff (rst)
    !init_n |-> (astrobe_n && dstrobe_n));

endmodule

bind epp_host_engine epp_host_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .write_n(write_n), .astrobe_n(astrobe_n),
  .dstrobe_n(dstrobe_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .init_n(init_n), .done(done), .busy(busy), .err_flag(err_q)
);

// File: tb/tb_epp_host_engine.sv
module tb_epp_host_engine;

  localparam int W  = 8;
  localparam int TO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]   req_addr  = '0;
  logic [W-1:0] req_wdata = '0;
  logic         done, busy, bus_oe, write_n, astrobe_n, dstrobe_n, init_n, irq;
  logic [W-1:0] rdata, bus_out;
  logic [W-1:0] bus_in = '0;
  logic         wait_n = 1'b0;
  logic         intr   = 1'b0;

  epp_host_engine #(.DATA_W(W), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .busy(busy),
    .rdata(rdata), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .write_n(write_n), .astrobe_n(astrobe_n), .dstrobe_n(dstrobe_n),
    .wait_n(wait_n), .intr(intr), .init_n(init_n), .irq(irq)
  );

  int n_checks = 0;
  int n_err    = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- peripheral model ----------------
  bit         mute = 1'b0;
  int         d1 = 1, d2 = 1;
  logic [7:0] paddr = 8'h00;
  logic [7:0] pmem [256];
  int         strobes = 0;
  bit         last_kind, last_wn, last_oe;
  logic [7:0] last_byte;

  initial begin
    for (int i = 0; i < 256; i++) pmem[i] = 8'(i) ^ 8'hA5;
    forever begin
      @(negedge clk);
      if (!mute && (!astrobe_n || !dstrobe_n)) begin
        last_kind = !dstrobe_n;
        last_wn   = write_n;
        last_oe   = bus_oe;
        if (write_n) bus_in = last_kind ? pmem[paddr] : paddr;
        repeat (d1) @(negedge clk);
        wait_n = 1'b1;
        while (!astrobe_n || !dstrobe_n) @(negedge clk);
        last_byte = bus_out;
        if (!last_wn) begin
          if (last_kind) pmem[paddr] = last_byte;
          else           paddr       = last_byte;
        end
        strobes++;
        repeat (d2) @(negedge clk);
        bus_in = '0;
        wait_n = 1'b0;
      end
    end
  end

  // ---------------- bench shadow of expected peripheral state ----------------
  logic [7:0] sh_addr = 8'h00;
  logic [7:0] sh_mem [256];

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  function automatic bit exp_kind(input logic [2:0] a);
    return (a != 3'd3);   // R2: 3 -> address, 4..7 -> data
  endfunction

  // ---------------- access tasks ----------------
  task automatic issue(input bit wr, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [7:0] r, output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    r = rdata;
    if (cyc >= 3000) check(1'b0, "R5 done never seen", 0, 1);
  endtask

  task automatic access(input bit wr, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] r);
    int c;
    issue(wr, a, d);
    wait_done(r, c);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_up();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] r, v;
    int         s0, cyc;
    void'($urandom(32'd1284));
    for (int i = 0; i < 256; i++) sh_mem[i] = init_val(i);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(write_n && astrobe_n && dstrobe_n && init_n, "R1 idle pins", {write_n, astrobe_n, dstrobe_n, init_n}, 4'hF);
    check(bus_oe && bus_out == 8'h00, "R1 idle bus", {bus_oe, bus_out}, 9'h100);
    check(!busy && !done && !irq, "R1 flags", {busy, done, irq}, 0);

    // R7 local registers
    access(1'b1, 3'd0, 8'hC3, r);
    check(bus_out == 8'hC3 && bus_oe, "R7 data reg on idle bus", bus_out, 8'hC3);
    access(1'b0, 3'd0, 8'h00, r);
    check(r == 8'hC3, "R7 data reg read", r, 8'hC3);
    access(1'b1, 3'd2, 8'h01, r);
    access(1'b0, 3'd2, 8'h00, r);
    check(r == 8'h01, "R7 control read", r, 8'h01);
    access(1'b0, 3'd1, 8'h00, r);
    check(r == 8'h80, "R7 status ready", r, 8'h80);
    access(1'b1, 3'd2, 8'h00, r);

    // R2/R3/R4 random cycles
    for (int k = 0; k < 60; k++) begin
      int          op;
      logic [2:0]  a;
      op = $urandom_range(0, 3);
      d1 = $urandom_range(1, 5);
      d2 = $urandom_range(1, 5);
      a  = (op < 2) ? 3'd3 : 3'($urandom_range(4, 7));
      v  = 8'($urandom);
      s0 = strobes;
      access(op[0] == 1'b0, a, v, r);
      check(strobes == s0 + 1, "R2 one strobe per access", strobes - s0, 1);
      check(last_kind == exp_kind(a), "R2 strobe line", last_kind, exp_kind(a));
      check(wait_n == 1'b0, "R5 done after ready", wait_n, 0);
      if (op[0] == 1'b0) begin
        check(!last_wn && last_oe, "R3 write direction", {last_wn, last_oe}, 2'b01);
        check(last_byte == v, "R3 latched byte", last_byte, v);
        if (a == 3'd3) sh_addr = v;
        else           sh_mem[sh_addr] = v;
      end else begin
        check(last_wn && !last_oe, "R4 read direction", {last_wn, last_oe}, 2'b10);
        if (a == 3'd3) check(r == sh_addr, "R4 address read", r, sh_addr);
        else           check(r == sh_mem[sh_addr], "R4 data read", r, sh_mem[sh_addr]);
      end
    end

    // R5 no strobe while peripheral not ready
    d1 = 2; d2 = 2;
    mute = 1'b1; wait_n = 1'b1;
    issue(1'b1, 3'd4, 8'h3C);
    repeat (10) @(negedge clk);
    check(dstrobe_n && busy, "R5 strobe held off", {dstrobe_n, busy}, 2'b11);
    wait_n = 1'b0; mute = 1'b0;
    wait_done(r, cyc);
    check(last_byte == 8'h3C && last_kind, "R5 cycle after ready", last_byte, 8'h3C);
    sh_mem[sh_addr] = 8'h3C;

    // R10 request while busy is ignored
    d1 = 20;
    access(1'b1, 3'd0, 8'h5E, r);
    issue(1'b1, 3'd5, 8'h91);
    issue(1'b1, 3'd0, 8'h77);
    wait_done(r, cyc);
    access(1'b0, 3'd0, 8'h00, r);
    check(r == 8'h5E, "R10 busy request ignored", r, 8'h5E);
    d1 = 2;

    // R6 timeout
    mute = 1'b1; wait_n = 1'b0;
    issue(1'b0, 3'd5, 8'h00);
    wait_done(r, cyc);
    check(r == 8'h00, "R6 aborted read data", r, 0);
    check(cyc >= TO - 4 && cyc <= TO + 8, "R6 abort time", cyc, TO);
    check(dstrobe_n, "R6 strobe released", dstrobe_n, 1);
    access(1'b0, 3'd1, 8'h00, r);
    check(r[0] == 1'b1, "R6 error sticky", r, 8'h81);
    access(1'b1, 3'd2, 8'h04, r);
    access(1'b0, 3'd1, 8'h00, r);
    check(r[0] == 1'b0, "R6 error cleared", r, 8'h80);
    mute = 1'b0;

    // R8 link reset
    access(1'b1, 3'd2, 8'h02, r);
    check(init_n == 1'b0, "R8 init asserted", init_n, 0);
    s0 = strobes;
    access(1'b1, 3'd6, 8'h11, r);
    access(1'b0, 3'd3, 8'h00, r);
    check(strobes == s0, "R8 no strobe", strobes - s0, 0);
    check(r == 8'h00, "R8 read returns zero", r, 0);
    access(1'b1, 3'd2, 8'h00, r);
    check(init_n == 1'b1, "R8 init released", init_n, 1);

    // R9 interrupt
    access(1'b1, 3'd2, 8'h01, r);
    intr = 1'b1;
    repeat (8) @(negedge clk);
    check(irq == 1'b1, "R9 irq raised", irq, 1);
    access(1'b0, 3'd1, 8'h00, r);
    check(r[1] && r[6], "R9 pending and level", r, 8'hC2);
    access(1'b1, 3'd2, 8'h09, r);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R9 irq cleared", irq, 0);
    intr = 1'b0;
    access(1'b1, 3'd2, 8'h00, r);
    repeat (4) @(negedge clk);
    intr = 1'b1;
    repeat (8) @(negedge clk);
    check(irq == 1'b0, "R9 masked irq", irq, 0);
    access(1'b0, 3'd1, 8'h00, r);
    check(r[1] == 1'b1, "R9 pending while masked", r[1], 1);

    finish_up();
  end

endmodule